// File: doc/BRIEF.md
# Dual-PLL Serial Divider Word Loader

This block takes divider control words for two frequency synthesizers from a three-wire serial port: a data line, a shift clock and an active-low load enable. Each word is 22 bits long and arrives most significant bit first. The two bits that arrive last are an address. They steer the word into one of four holding registers: the reference divider or the main divider of synthesizer 1 or synthesizer 2. A word is committed on the rising edge of the enable line, and only if exactly 22 bits were shifted in while the enable was low.

The three serial lines are asynchronous to the system clock. Each line passes through a two-stage synchronizer, and the edges of the shift clock and the enable are found in the system clock domain. A reference-divider word holds a five-bit mode field and a fifteen-bit ratio. A ratio below 3 is illegal. Such a word leaves the register untouched and raises a one-cycle error pulse. A main-divider word is stored as twenty opaque bits.

The serial port has no ready signal because the sender cannot be held off. The parallel outputs are plain register levels. A one-cycle update strobe per register tells downstream logic when to reload. Back-pressure does not apply anywhere in this block.

Top module: `dual_pll_word_loader`

## Requirements
- R1: While the synchronized enable is low, every rising edge of the synchronized shift clock shifts the synchronized data bit into the word. The first bit sent becomes word bit 21 and the last bit sent becomes word bit 0.
- R2: A word is committed only when enable rises after exactly 22 shift-clock rising edges since enable last fell. Any other count, fewer or more, changes no register, raises no strobe and raises no error.
- R3: Word bits [1:0] select the target register: 2'b00 is the synthesizer-2 reference register, 2'b01 is the synthesizer-2 main register, 2'b10 is the synthesizer-1 reference register and 2'b11 is the synthesizer-1 main register.
- R4: A committed reference word loads mode = word[21:17] and ratio = word[16:2] into the selected synthesizer, and sets that synthesizer's ratio_ok output.
- R5: A committed main word loads word[21:2] as that synthesizer's 20-bit main value.
- R6: A reference word whose ratio is 0, 1 or 2 leaves the target's ratio, mode and ratio_ok unchanged. It raises ratio_err for exactly one cycle and raises no strobe. Ratios 3 and 32767 are accepted.
- R7: upd_stb has one bit per register, with the bit index equal to the select code of R3. Exactly that one bit is high, for one cycle, in the same cycle the register takes its new value.
- R8: After reset every ratio, mode and main output is zero, both ratio_ok outputs are low, and upd_stb and ratio_err are low. A ratio_ok stays high once it has been set.
- R9: Register outputs, strobe and error change on the third system clock rising edge after the edge that first samples the enable pin high.
- R10: Shift-clock edges while enable is high shift nothing. A fall of enable clears the bit count, so bits sent before an aborted frame do not count toward the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_data | input | 1 | Serial data line, asynchronous |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_en | input | 1 | Serial load enable, low during a frame |
| pll1_ratio | output | 15 | Synthesizer-1 reference ratio |
| pll1_mode | output | 5 | Synthesizer-1 reference mode bits |
| pll1_ratio_ok | output | 1 | Synthesizer-1 ratio has been loaded with a legal value |
| pll1_main | output | 20 | Synthesizer-1 main divider word |
| pll2_ratio | output | 15 | Synthesizer-2 reference ratio |
| pll2_mode | output | 5 | Synthesizer-2 reference mode bits |
| pll2_ratio_ok | output | 1 | Synthesizer-2 ratio has been loaded with a legal value |
| pll2_main | output | 20 | Synthesizer-2 main divider word |
| upd_stb | output | 4 | One-cycle update strobe per register, indexed by select code |
| ratio_err | output | 1 | One-cycle pulse when an illegal ratio is rejected |

## Verification
The properties assume that the serial lines are much slower than the system clock. Each level on the shift clock and data lines must be held for at least two system cycles. Data must settle before the shift clock rises, and the enable must never change in the same cycle as a shift-clock edge. Under these conditions no edge is lost in the synchronizers and commits are spaced far apart. The stimulus drives every pin change on a falling system clock edge and holds each level for two system cycles. It puts a two-cycle gap between any enable change and any shift-clock change, so these assumptions are never broken.

// File: rtl/pllw_pkg.sv
package pllw_pkg;
  // select codes (R3), encoded as in word bits [1:0]
  typedef enum logic [1:0] {
    SEL_P2_REF  = 2'b00,
    SEL_P2_MAIN = 2'b01,
    SEL_P1_REF  = 2'b10,
    SEL_P1_MAIN = 2'b11
  } pllw_sel_e;

  localparam int unsigned DEF_FRAME_W   = 22;
  localparam int unsigned DEF_SEL_W     = 2;
  localparam int unsigned DEF_RATIO_W   = 15;
  localparam int unsigned DEF_MODE_W    = 5;
  localparam int unsigned DEF_MIN_RATIO = 3;
  localparam int unsigned DEF_SYNC_N    = 2;
endpackage

// File: rtl/pllw_sync.sv
module pllw_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] level
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign level = chain[STAGES-1];
endmodule

// File: rtl/pllw_edge.sv
module pllw_edge #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= level;
  end

  assign rise = level & ~prev;
  assign fall = ~level & prev;
endmodule

// File: rtl/pllw_shifter.sv
module pllw_shifter #(
  parameter int unsigned FRAME_W = 22,
  parameter int unsigned CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_in,
  input  logic               tick,
  input  logic               clear,
  output logic [FRAME_W-1:0] word,
  output logic               full
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      cnt  <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (tick) begin
      word <= {word[FRAME_W-2:0], bit_in};
      if (cnt != {CNT_W{1'b1}}) cnt <= cnt + 1'b1;
    end
  end

  assign full = (cnt == CNT_W'(FRAME_W));
endmodule

// File: rtl/pllw_bank.sv
module pllw_bank #(
  parameter int unsigned FRAME_W   = 22,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned RATIO_W   = 15,
  parameter int unsigned MODE_W    = 5,
  parameter int unsigned MIN_RATIO = 3,
  localparam int unsigned MAIN_W   = FRAME_W - SEL_W,
  localparam int unsigned NUM_PLL  = 2 ** (SEL_W - 1),
  localparam int unsigned NUM_REG  = 2 ** SEL_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        commit,
  input  logic [FRAME_W-1:0]          word,
  output logic [NUM_PLL*RATIO_W-1:0]  ratio_o,
  output logic [NUM_PLL*MODE_W-1:0]   mode_o,
  output logic [NUM_PLL-1:0]          ok_o,
  output logic [NUM_PLL*MAIN_W-1:0]   main_o,
  output logic [NUM_REG-1:0]          stb_o,
  output logic                        err_o
);
  logic [SEL_W-1:0]   sel;
  logic [RATIO_W-1:0] ratio_f;
  logic [MODE_W-1:0]  mode_f;
  logic [MAIN_W-1:0]  main_f;
  logic               is_main;
  logic               ratio_legal;

  assign sel         = word[SEL_W-1:0];
  assign ratio_f     = word[SEL_W +: RATIO_W];
  assign mode_f      = word[SEL_W+RATIO_W +: MODE_W];
  assign main_f      = word[FRAME_W-1:SEL_W];
  assign is_main     = sel[0];
  assign ratio_legal = (ratio_f >= RATIO_W'(MIN_RATIO));

  generate
    for (genvar p = 0; p < NUM_PLL; p++) begin : g_pll
      // slot 0 is synthesizer 1, which owns the high select codes
      localparam int unsigned CODE_HI  = NUM_PLL - 1 - p;
      localparam int unsigned REF_IDX  = CODE_HI * 2;
      localparam int unsigned MAIN_IDX = REF_IDX + 1;

      logic               hit;
      logic               ref_load;
      logic               main_load;
      logic [RATIO_W-1:0] ratio_q;
      logic [MODE_W-1:0]  mode_q;
      logic [MAIN_W-1:0]  main_q;
      logic               ok_q;
      logic               ref_stb_q;
      logic               main_stb_q;

      assign hit       = commit && (sel[SEL_W-1:1] == (SEL_W-1)'(CODE_HI));
      assign ref_load  = hit && !is_main && ratio_legal;
      assign main_load = hit && is_main;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ratio_q <= '0;
          mode_q  <= '0;
          ok_q    <= 1'b0;
        end else if (ref_load) begin
          ratio_q <= ratio_f;
          mode_q  <= mode_f;
          ok_q    <= 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         main_q <= '0;
        else if (main_load) main_q <= main_f;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ref_stb_q  <= 1'b0;
          main_stb_q <= 1'b0;
        end else begin
          ref_stb_q  <= ref_load;
          main_stb_q <= main_load;
        end
      end

      assign ratio_o[p*RATIO_W +: RATIO_W] = ratio_q;
      assign mode_o[p*MODE_W +: MODE_W]    = mode_q;
      assign main_o[p*MAIN_W +: MAIN_W]    = main_q;
      assign ok_o[p]                       = ok_q;
      assign stb_o[REF_IDX]                = ref_stb_q;
      assign stb_o[MAIN_IDX]               = main_stb_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_o <= 1'b0;
    else        err_o <= commit && !is_main && !ratio_legal;
  end
endmodule

// File: rtl/dual_pll_word_loader.sv
module dual_pll_word_loader #(
  parameter int unsigned FRAME_W   = pllw_pkg::DEF_FRAME_W,
  parameter int unsigned SEL_W     = pllw_pkg::DEF_SEL_W,
  parameter int unsigned RATIO_W   = pllw_pkg::DEF_RATIO_W,
  parameter int unsigned MODE_W    = pllw_pkg::DEF_MODE_W,
  parameter int unsigned MIN_RATIO = pllw_pkg::DEF_MIN_RATIO,
  parameter int unsigned SYNC_N    = pllw_pkg::DEF_SYNC_N,
  localparam int unsigned MAIN_W   = FRAME_W - SEL_W,
  localparam int unsigned NUM_REG  = 2 ** SEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_data,
  input  logic               ser_clk,
  input  logic               ser_en,
  output logic [RATIO_W-1:0] pll1_ratio,
  output logic [MODE_W-1:0]  pll1_mode,
  output logic               pll1_ratio_ok,
  output logic [MAIN_W-1:0]  pll1_main,
  output logic [RATIO_W-1:0] pll2_ratio,
  output logic [MODE_W-1:0]  pll2_mode,
  output logic               pll2_ratio_ok,
  output logic [MAIN_W-1:0]  pll2_main,
  output logic [NUM_REG-1:0] upd_stb,
  output logic               ratio_err
);
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1) + 1;
  localparam int unsigned NUM_PLL = 2 ** (SEL_W - 1);

  // synchronized lines: [2]=enable, [1]=shift clock, [0]=data
  logic [2:0] lvl;
  logic [1:0] rise;
  logic [1:0] fall;
  logic       shift_tick;
  logic       frame_clear;
  logic       commit;
  logic       frame_full;
  logic [FRAME_W-1:0] word;

  logic [NUM_PLL*RATIO_W-1:0] ratio_v;
  logic [NUM_PLL*MODE_W-1:0]  mode_v;
  logic [NUM_PLL-1:0]         ok_v;
  logic [NUM_PLL*MAIN_W-1:0]  main_v;

  pllw_sync #(.W(3), .STAGES(SYNC_N)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in({ser_en, ser_clk, ser_data}),
    .level   (lvl)
  );

  // edge finder on {enable, shift clock}
  pllw_edge #(.W(2)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .level(lvl[2:1]),
    .rise (rise),
    .fall (fall)
  );

  assign shift_tick  = rise[0] && !lvl[2];
  assign frame_clear = fall[1];
  assign commit      = rise[1] && frame_full;

  pllw_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .bit_in(lvl[0]),
    .tick  (shift_tick && !fall[0]),
    .clear (frame_clear),
    .word  (word),
    .full  (frame_full)
  );

  pllw_bank #(
    .FRAME_W  (FRAME_W),
    .SEL_W    (SEL_W),
    .RATIO_W  (RATIO_W),
    .MODE_W   (MODE_W),
    .MIN_RATIO(MIN_RATIO)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (commit),
    .word   (word),
    .ratio_o(ratio_v),
    .mode_o (mode_v),
    .ok_o   (ok_v),
    .main_o (main_v),
    .stb_o  (upd_stb),
    .err_o  (ratio_err)
  );

  assign pll1_ratio    = ratio_v[0 +: RATIO_W];
  assign pll1_mode     = mode_v[0 +: MODE_W];
  assign pll1_ratio_ok = ok_v[0];
  assign pll1_main     = main_v[0 +: MAIN_W];
  assign pll2_ratio    = ratio_v[RATIO_W +: RATIO_W];
  assign pll2_mode     = mode_v[MODE_W +: MODE_W];
  assign pll2_ratio_ok = ok_v[1];
  assign pll2_main     = main_v[MAIN_W +: MAIN_W];
endmodule

// File: rtl/pllw_checker.sv
module pllw_checker #(
  parameter int unsigned RATIO_W   = 15,
  parameter int unsigned MAIN_W    = 20,
  parameter int unsigned NUM_REG   = 4,
  parameter int unsigned MIN_RATIO = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [RATIO_W-1:0] pll1_ratio,
  input logic               pll1_ratio_ok,
  input logic [MAIN_W-1:0]  pll1_main,
  input logic [RATIO_W-1:0] pll2_ratio,
  input logic               pll2_ratio_ok,
  input logic [MAIN_W-1:0]  pll2_main,
  input logic [NUM_REG-1:0] upd_stb,
  input logic               ratio_err
);
  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_stb)); // R7
  AST_ERR_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_err |-> (upd_stb == '0)); // R6
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_err |=> !ratio_err); // R6
  AST_P1_RATIO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pll1_ratio_ok |-> (pll1_ratio >= RATIO_W'(MIN_RATIO))); // R6
  AST_P2_RATIO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pll2_ratio_ok |-> (pll2_ratio >= RATIO_W'(MIN_RATIO))); // R6
  AST_P1_REF_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pll1_ratio) |-> upd_stb[2]); // R7
  AST_P2_REF_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pll2_ratio) |-> upd_stb[0]); // R3
  AST_P1_MAIN_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pll1_main) |-> upd_stb[3]); // R5
  AST_P2_MAIN_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pll2_main) |-> upd_stb[1]); // R5
  AST_P1_OK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pll1_ratio_ok |=> pll1_ratio_ok); // R8
  AST_P2_OK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pll2_ratio_ok |=> pll2_ratio_ok); // R8
endmodule

bind dual_pll_word_loader pllw_checker #(
  .RATIO_W  (RATIO_W),
  .MAIN_W   (MAIN_W),
  .NUM_REG  (NUM_REG),
  .MIN_RATIO(MIN_RATIO)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pll1_ratio   (pll1_ratio),
  .pll1_ratio_ok(pll1_ratio_ok),
  .pll1_main    (pll1_main),
  .pll2_ratio   (pll2_ratio),
  .pll2_ratio_ok(pll2_ratio_ok),
  .pll2_main    (pll2_main),
  .upd_stb      (upd_stb),
  .ratio_err    (ratio_err)
);

// File: tb/dual_pll_word_loader_test.sv
module dual_pll_word_loader_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_data = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_en = 1'b1;

  logic [14:0] pll1_ratio, pll2_ratio;
  logic [4:0]  pll1_mode, pll2_mode;
  logic        pll1_ratio_ok, pll2_ratio_ok;
  logic [19:0] pll1_main, pll2_main;
  logic [3:0]  upd_stb;
  logic        ratio_err;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int err_seen = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_pll_word_loader uut (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk), .ser_en(ser_en),
    .pll1_ratio(pll1_ratio), .pll1_mode(pll1_mode), .pll1_ratio_ok(pll1_ratio_ok),
    .pll1_main(pll1_main), .pll2_ratio(pll2_ratio), .pll2_mode(pll2_mode),
    .pll2_ratio_ok(pll2_ratio_ok), .pll2_main(pll2_main),
    .upd_stb(upd_stb), .ratio_err(ratio_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // pin history, newest first: {en, clk, data}; updates land 3 edges after sampling (R9)
  logic [2:0]  hist[$];
  logic [21:0] m_word;
  int          m_cnt;
  logic [14:0] m_ratio[2];
  logic [4:0]  m_mode[2];
  logic        m_ok[2];
  logic [19:0] m_main[2];
  logic [3:0]  m_stb;
  logic        m_err;

  always @(posedge clk) begin
    logic [2:0] cur, prv;
    int slot;
    m_stb = '0;
    m_err = 1'b0;
    if (!rst_n) begin
      hist = '{3'b0, 3'b0, 3'b0, 3'b0};
      m_word = '0;
      m_cnt = 0;
      for (int i = 0; i < 2; i++) begin
        m_ratio[i] = '0; m_mode[i] = '0; m_ok[i] = 1'b0; m_main[i] = '0;
      end
    end else begin
      hist.push_front({ser_en, ser_clk, ser_data});
      if (hist.size() > 4) void'(hist.pop_back());
      cur = hist[2];
      prv = hist[3];
      if (cur[2] && !prv[2]) begin
        if (m_cnt == 22) begin
          slot = m_word[1] ? 0 : 1;
          if (m_word[0]) begin
            m_main[slot] = m_word[21:2];
            m_stb[m_word[1:0]] = 1'b1;
          end else if (m_word[16:2] >= 3) begin
            m_ratio[slot] = m_word[16:2];
            m_mode[slot] = m_word[21:17];
            m_ok[slot] = 1'b1;
            m_stb[m_word[1:0]] = 1'b1;
          end else begin
            m_err = 1'b1;
          end
        end
      end else if (!cur[2] && prv[2]) begin
        m_cnt = 0;
      end else if (cur[1] && !prv[1] && !cur[2]) begin
        m_word = {m_word[20:0], cur[0]};
        if (m_cnt < 63) m_cnt++;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 pll1 ratio", 32'(pll1_ratio), 32'(m_ratio[0]));
      chk("R4 pll1 mode", 32'(pll1_mode), 32'(m_mode[0]));
      chk("R8 pll1 ratio_ok", 32'(pll1_ratio_ok), 32'(m_ok[0]));
      chk("R5 pll1 main", 32'(pll1_main), 32'(m_main[0]));
      chk("R3 pll2 ratio", 32'(pll2_ratio), 32'(m_ratio[1]));
      chk("R3 pll2 mode", 32'(pll2_mode), 32'(m_mode[1]));
      chk("R8 pll2 ratio_ok", 32'(pll2_ratio_ok), 32'(m_ok[1]));
      chk("R5 pll2 main", 32'(pll2_main), 32'(m_main[1]));
      chk("R7 upd_stb", 32'(upd_stb), 32'(m_stb));
      chk("R6 ratio_err", 32'(ratio_err), 32'(m_err));
      if (ratio_err) err_seen++;
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [31:0] ref_word(input logic [4:0] mode, input logic [14:0] r,
                                           input logic [1:0] sel);
    return {10'b0, mode, r, sel};
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = w[i];
      wait_n(2);
      ser_clk = 1'b1;
      wait_n(2);
      ser_clk = 1'b0;
      wait_n(2);
    end
  endtask

  // kind: 0 = no effect, 1 = strobe expected, 2 = error expected (R9 latency)
  task automatic send(input logic [31:0] w, input int n, input int kind);
    @(negedge clk);
    ser_en = 1'b0;
    wait_n(2);
    shift_bits(w, n);
    ser_en = 1'b1;
    wait_n(2);
    chk("R9 no early strobe", 32'(upd_stb), 32'h0);
    chk("R9 no early error", 32'(ratio_err), 32'h0);
    wait_n(1);
    chk("R9 strobe on third edge", 32'(upd_stb != 0), 32'(kind == 1));
    chk("R9 error on third edge", 32'(ratio_err), 32'(kind == 2));
    wait_n(3);
  endtask

  initial begin
    int e0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(3);
    // R8 reset state
    chk("R8 reset pll1 ratio", 32'(pll1_ratio), 32'h0);
    chk("R8 reset pll2 main", 32'(pll2_main), 32'h0);
    chk("R8 reset ok flags", 32'({pll1_ratio_ok, pll2_ratio_ok}), 32'h0);
    chk("R8 reset strobes", 32'(upd_stb), 32'h0);

    // R1 R4: synthesizer-1 reference, select 2'b10
    send(ref_word(5'h15, 15'd1000, 2'b10), 22, 1);
    chk("R1 R4 pll1 ratio", 32'(pll1_ratio), 32'd1000);
    chk("R4 pll1 mode", 32'(pll1_mode), 32'h15);
    chk("R4 pll1 ok", 32'(pll1_ratio_ok), 32'h1);

    // R5: synthesizer-1 main, select 2'b11
    send({10'b0, 20'hABCDE, 2'b11}, 22, 1);
    chk("R5 pll1 main", 32'(pll1_main), 32'hABCDE);

    // R3: synthesizer-2 registers, selects 2'b00 and 2'b01, boundary ratio 3
    send(ref_word(5'h1F, 15'd3, 2'b00), 22, 1);
    chk("R3 R6 pll2 ratio min", 32'(pll2_ratio), 32'd3);
    chk("R3 pll2 mode", 32'(pll2_mode), 32'h1F);
    send({10'b0, 20'h12345, 2'b01}, 22, 1);
    chk("R3 pll2 main", 32'(pll2_main), 32'h12345);
    chk("R3 pll1 main untouched", 32'(pll1_main), 32'hABCDE);

    // R6: illegal ratios rejected
    e0 = err_seen;
    send(ref_word(5'h0A, 15'd2, 2'b00), 22, 2);
    send(ref_word(5'h0B, 15'd0, 2'b10), 22, 2);
    chk("R6 error pulses", 32'(err_seen - e0), 32'd2);
    chk("R6 pll2 ratio kept", 32'(pll2_ratio), 32'd3);
    chk("R6 pll1 mode kept", 32'(pll1_mode), 32'h15);
    send(ref_word(5'h01, 15'd32767, 2'b10), 22, 1);
    chk("R6 max ratio", 32'(pll1_ratio), 32'd32767);

    // R2: wrong bit counts discarded
    send(ref_word(5'h02, 15'd500, 2'b10), 21, 0);
    send({9'b0, 1'b1, 20'h55555, 2'b11}, 23, 0);
    chk("R2 short frame ignored", 32'(pll1_ratio), 32'd32767);
    chk("R2 long frame ignored", 32'(pll1_main), 32'hABCDE);

    // R10: pulses with enable high, then an aborted partial frame
    wait_n(2);
    shift_bits(32'h0000_0FFF, 12);
    @(negedge clk);
    ser_en = 1'b0;
    wait_n(2);
    shift_bits(32'h1F, 5);
    ser_en = 1'b1;
    wait_n(6);
    chk("R10 aborted frame no strobe", 32'(pll2_main), 32'h12345);
    send({10'b0, 20'h0F0F0, 2'b01}, 22, 1);
    chk("R10 count cleared on fall", 32'(pll2_main), 32'h0F0F0);

    wait_n(4);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule